// File: doc/BRIEF.md
# Target-Side Automatic Byte Handshake Sequencer

This block moves one byte at a time across an asynchronous SCSI bus while acting as the target. A processor programs the bus phase (message, command/data and direction bits). For an outbound byte it also loads the byte to send. It then sets a start bit. The sequencer performs the REQ/ACK exchange without further processor help:

- It presents the phase and, for outbound bytes, the data with odd parity.
- It raises REQ and waits for the initiator's ACK.
- It drops REQ and waits for ACK to fall.
- It then reports completion.

Completion is reported through a command-done flag and an interrupt line. The interrupt is the OR of command-done and error. Both flags are cleared by writing 1 to them.

For inbound bytes the sequencer captures the byte and its parity bit on the synchronized rising edge of ACK, checks odd parity, and leaves the byte readable. A parity failure sets the error flag and a cause bit. An initiator that does not respond within a programmable number of clocks causes an abort. The abort drops REQ and sets a second cause bit. Each arming transfers exactly one byte.

Top module: `pio_target_seq`

## Requirements
- R1: After reset, busReq, busDataOe, irq, startBit, doneFlag and errFlag are 0, errCause is 0 and busPhase is 0.
- R2: A cpuStart pulse sampled at clock edge k, while the sequencer is idle, makes startBit read 1 after edge k. startBit reads 0 after edge k+1, and busReq rises after edge k+2.
- R3: Phase encoding is bit 2 = message, bit 1 = command/data, bit 0 = direction (1 = target drives data). While a handshake runs, busPhase shows the phase register as it was at arming, and phase writes during the handshake do not change it. busPhase is 0 when idle.
- R4: With direction bit 1, busDataOe is 1 from the clock before busReq rises until the handshake ends. busDataOut carries the byte held at arming, and busParOut makes the nine bits hold an odd number of ones.
- R5: busReq stays high until ACK (two-flop synchronized) is seen high, and then falls. The byte is not complete, and doneFlag stays 0, until ACK is seen low again.
- R6: With direction bit 0, busDataOe stays 0, and busDataIn is captured on the synchronized rising edge of ACK. After completion the byte is readable on rxData.
- R7: Completion of a handshake sets doneFlag and raises irq.
- R8: An inbound byte whose nine bits (data plus busParIn) hold an even number of ones sets errFlag and errCause bit 0 at completion. doneFlag is still set.
- R9: If ACK does not change for TIMEOUT_CYC clocks in either wait, the sequencer drops busReq and returns to idle. It then sets errFlag and errCause bit 1 and leaves doneFlag 0.
- R10: irq equals doneFlag OR errFlag. Writing cpuClrWe with cpuClrMask bit 0 = 1 clears doneFlag, and bit 1 = 1 clears errFlag and errCause. Mask bits of 0 leave the flags unchanged.
- R11: A cpuStart pulse while a handshake is running is ignored, so no second handshake follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuPhaseWe | input | 1 | Write strobe for the phase register |
| cpuPhaseVal | input | 3 | Phase value {message, command/data, direction} |
| cpuTxWe | input | 1 | Write strobe for the outbound byte register |
| cpuTxVal | input | DATA_W | Outbound byte |
| cpuStart | input | 1 | Sets the start bit (arms one byte) |
| cpuClrWe | input | 1 | Write strobe for write-1-to-clear of the flags |
| cpuClrMask | input | 2 | Bit 0 clears done, bit 1 clears error and cause |
| startBit | output | 1 | Self-clearing start bit |
| doneFlag | output | 1 | Command-done flag |
| errFlag | output | 1 | Error flag |
| errCause | output | 2 | Bit 0 parity failure, bit 1 handshake timeout |
| rxData | output | DATA_W | Last captured inbound byte |
| irq | output | 1 | Interrupt request |
| busReq | output | 1 | REQ to the bus |
| busAck | input | 1 | ACK from the bus (asynchronous) |
| busPhase | output | 3 | Phase lines driven during a handshake |
| busDataOut | output | DATA_W | Outbound data lines |
| busParOut | output | 1 | Outbound odd parity |
| busDataIn | input | DATA_W | Inbound data lines |
| busParIn | input | 1 | Inbound parity line |
| busDataOe | output | 1 | Drive enable for data and parity |

## Verification
The bench builds the block with DATA_W = 8 and TIMEOUT_CYC = 16. A short timeout makes the abort path (R9) reachable within a few dozen clocks, and it can be exercised in both ACK waits. The default data width keeps the parity vectors small enough to pick by hand: one byte with good parity and one with bad parity. An initiator model in the bench stretches ACK by chosen amounts, so the REQ hold and the completion gating of R5 are observed across the synchronizer delay.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
  localparam int PHASE_W = 3;
  localparam int DIR_BIT = 0;
  localparam int CAUSE_W = 2;
  localparam int CAUSE_PAR = 0;
  localparam int CAUSE_TMO = 1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACKHI  = 2'd2,
    ST_ACKLO  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic launch;   // snapshot phase/data, clear start bit
    logic capture;  // latch inbound byte and parity verdict
    logic finish;   // handshake completed normally
    logic abort;    // timeout
  } seqStrobe_t;
endpackage

// File: rtl/pio_seq_ctrl.sv
module pio_seq_ctrl
  import pio_seq_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startBit,
  input  logic       ackSync,
  output seqStrobe_t strobe,
  output logic       active,
  output logic       reqOut
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  seqState_t state, stateNxt;
  logic [CNT_W-1:0] waitCnt, waitCntNxt;

  always_comb begin
    stateNxt   = state;
    waitCntNxt = waitCnt;
    strobe     = '0;
    unique case (state)
      ST_IDLE: begin
        if (startBit) begin
          strobe.launch = 1'b1;
          stateNxt      = ST_SETUP;
        end
      end
      ST_SETUP: begin
        waitCntNxt = '0;
        stateNxt   = ST_ACKHI;
      end
      ST_ACKHI: begin
        if (ackSync) begin
          strobe.capture = 1'b1;
          waitCntNxt     = '0;
          stateNxt       = ST_ACKLO;
        end else if (waitCnt == CNT_LAST) begin
          strobe.abort = 1'b1;
          stateNxt     = ST_IDLE;
        end else begin
          waitCntNxt = waitCnt + 1'b1;
        end
      end
      ST_ACKLO: begin
        if (!ackSync) begin
          strobe.finish = 1'b1;
          stateNxt      = ST_IDLE;
        end else if (waitCnt == CNT_LAST) begin
          strobe.abort = 1'b1;
          stateNxt     = ST_IDLE;
        end else begin
          waitCntNxt = waitCnt + 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state   <= stateNxt;
      waitCnt <= waitCntNxt;
    end
  end

  assign active = (state != ST_IDLE);
  assign reqOut = (state == ST_ACKHI);
endmodule

// File: rtl/pio_seq_dpath.sv
module pio_seq_dpath
  import pio_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuPhaseWe,
  input  logic [PHASE_W-1:0] cpuPhaseVal,
  input  logic               cpuTxWe,
  input  logic [DATA_W-1:0]  cpuTxVal,
  input  logic               cpuStart,
  input  logic               cpuClrWe,
  input  logic [CAUSE_W-1:0] cpuClrMask,
  input  seqStrobe_t         strobe,
  input  logic               active,
  input  logic               busAck,
  input  logic [DATA_W-1:0]  busDataIn,
  input  logic               busParIn,
  output logic               ackSync,
  output logic               startBit,
  output logic               doneFlag,
  output logic               errFlag,
  output logic [CAUSE_W-1:0] errCause,
  output logic [DATA_W-1:0]  rxData,
  output logic [PHASE_W-1:0] busPhase,
  output logic [DATA_W-1:0]  busDataOut,
  output logic               busParOut,
  output logic               busDataOe
);
  logic [PHASE_W-1:0] phaseReg, phaseSnap;
  logic [DATA_W-1:0]  txReg, txSnap;
  logic               ackMeta;
  logic               rxParBad;
  logic               inParOk;

  // odd parity: data plus parity bit must hold an odd count of ones
  assign inParOk = ^{busDataIn, busParIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackMeta <= 1'b0;
      ackSync <= 1'b0;
    end else begin
      ackMeta <= busAck;
      ackSync <= ackMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseReg <= '0;
      txReg    <= '0;
    end else begin
      if (cpuPhaseWe) phaseReg <= cpuPhaseVal;
      if (cpuTxWe)    txReg    <= cpuTxVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startBit <= 1'b0;
    end else if (strobe.launch) begin
      startBit <= 1'b0;
    end else if (cpuStart && !active) begin
      startBit <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseSnap <= '0;
      txSnap    <= '0;
    end else if (strobe.launch) begin
      phaseSnap <= phaseReg;
      txSnap    <= txReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData   <= '0;
      rxParBad <= 1'b0;
    end else if (strobe.capture && !phaseSnap[DIR_BIT]) begin
      rxData   <= busDataIn;
      rxParBad <= !inParOk;
    end else if (strobe.launch) begin
      rxParBad <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
    end else if (strobe.finish) begin
      doneFlag <= 1'b1;
    end else if (cpuClrWe && cpuClrMask[0]) begin
      doneFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag  <= 1'b0;
      errCause <= '0;
    end else if (strobe.finish && rxParBad && !phaseSnap[DIR_BIT]) begin
      errFlag             <= 1'b1;
      errCause[CAUSE_PAR] <= 1'b1;
    end else if (strobe.abort) begin
      errFlag             <= 1'b1;
      errCause[CAUSE_TMO] <= 1'b1;
    end else if (cpuClrWe && cpuClrMask[1]) begin
      errFlag  <= 1'b0;
      errCause <= '0;
    end
  end

  assign busPhase   = active ? phaseSnap : '0;
  assign busDataOe  = active && phaseSnap[DIR_BIT];
  assign busDataOut = txSnap;
  assign busParOut  = ~(^txSnap);
endmodule

// File: rtl/pio_target_seq.sv
module pio_target_seq
  import pio_seq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuPhaseWe,
  input  logic [2:0]        cpuPhaseVal,
  input  logic              cpuTxWe,
  input  logic [DATA_W-1:0] cpuTxVal,
  input  logic              cpuStart,
  input  logic              cpuClrWe,
  input  logic [1:0]        cpuClrMask,
  output logic              startBit,
  output logic              doneFlag,
  output logic              errFlag,
  output logic [1:0]        errCause,
  output logic [DATA_W-1:0] rxData,
  output logic              irq,
  output logic              busReq,
  input  logic              busAck,
  output logic [2:0]        busPhase,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busParOut,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              busParIn,
  output logic              busDataOe
);
  seqStrobe_t strobe;
  logic       active;
  logic       ackSync;

  pio_seq_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startBit (startBit),
    .ackSync  (ackSync),
    .strobe   (strobe),
    .active   (active),
    .reqOut   (busReq)
  );

  pio_seq_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .cpuPhaseWe  (cpuPhaseWe),
    .cpuPhaseVal (cpuPhaseVal),
    .cpuTxWe     (cpuTxWe),
    .cpuTxVal    (cpuTxVal),
    .cpuStart    (cpuStart),
    .cpuClrWe    (cpuClrWe),
    .cpuClrMask  (cpuClrMask),
    .strobe      (strobe),
    .active      (active),
    .busAck      (busAck),
    .busDataIn   (busDataIn),
    .busParIn    (busParIn),
    .ackSync     (ackSync),
    .startBit    (startBit),
    .doneFlag    (doneFlag),
    .errFlag     (errFlag),
    .errCause    (errCause),
    .rxData      (rxData),
    .busPhase    (busPhase),
    .busDataOut  (busDataOut),
    .busParOut   (busParOut),
    .busDataOe   (busDataOe)
  );

  assign irq = doneFlag | errFlag;
endmodule

// File: rtl/pio_target_seq_chk.sv
module pio_target_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              startBit,
  input logic              doneFlag,
  input logic              errFlag,
  input logic [1:0]        errCause,
  input logic              irq,
  input logic              busReq,
  input logic [2:0]        busPhase,
  input logic [DATA_W-1:0] busDataOut,
  input logic              busDataOe
);
  // R2: start bit clears itself one cycle after being set
  assert_start_selfclear_R2: assert property (@(posedge clk) disable iff (!rstN)
    startBit |=> !startBit);

  // R3: phase lines do not move while REQ is held
  assert_phase_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && $past(busReq)) |-> $stable(busPhase));

  // R4: outbound data is enabled a cycle before REQ rises
  assert_data_before_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busReq) && busPhase[0]) |-> $past(busDataOe));

  // R6: data drive only in the target-drives direction
  assert_oe_dir_R6: assert property (@(posedge clk) disable iff (!rstN)
    busDataOe |-> busPhase[0]);

  // R5: completion is reported only with REQ released
  assert_done_req_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> !busReq);

  // R9: a timeout cause never appears together with a fresh done
  assert_tmo_no_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errCause[1]) |-> !$rose(doneFlag));
endmodule

bind pio_target_seq pio_target_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startBit   (startBit),
  .doneFlag   (doneFlag),
  .errFlag    (errFlag),
  .errCause   (errCause),
  .irq        (irq),
  .busReq     (busReq),
  .busPhase   (busPhase),
  .busDataOut (busDataOut),
  .busDataOe  (busDataOe)
);

// File: tb/sim_pio_target_seq.sv
module sim_pio_target_seq;
  localparam int DW  = 8;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuPhaseWe = 0, cpuTxWe = 0, cpuStart = 0, cpuClrWe = 0;
  logic [2:0] cpuPhaseVal = '0;
  logic [DW-1:0] cpuTxVal = '0;
  logic [1:0] cpuClrMask = '0;
  logic startBit, doneFlag, errFlag, irq, busReq, busParOut, busDataOe;
  logic [1:0] errCause;
  logic [DW-1:0] rxData, busDataOut;
  logic [2:0] busPhase;
  logic busAck = 0, busParIn = 0;
  logic [DW-1:0] busDataIn = '0;

  always #5 clk = ~clk;

  pio_target_seq #(.DATA_W(DW), .TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rstN(rstN), .cpuPhaseWe(cpuPhaseWe), .cpuPhaseVal(cpuPhaseVal),
    .cpuTxWe(cpuTxWe), .cpuTxVal(cpuTxVal), .cpuStart(cpuStart),
    .cpuClrWe(cpuClrWe), .cpuClrMask(cpuClrMask), .startBit(startBit),
    .doneFlag(doneFlag), .errFlag(errFlag), .errCause(errCause), .rxData(rxData),
    .irq(irq), .busReq(busReq), .busAck(busAck), .busPhase(busPhase),
    .busDataOut(busDataOut), .busParOut(busParOut), .busDataIn(busDataIn),
    .busParIn(busParIn), .busDataOe(busDataOe));

  typedef struct packed {
    logic          done;
    logic          err;
    logic [1:0]    cause;
    logic          useRx;
    logic [DW-1:0] rx;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0;
  int nFails = 0;
  logic irqSeen = 0;
  int cyc = 0;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  // monitor: pops an expected item on each irq rise
  always @(negedge clk) begin
    if (rstN && irq && !irqSeen) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R7 unexpected irq", 32'(irq), 32'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        chk(doneFlag == e.done, "R7 done", 32'(doneFlag), 32'(e.done));
        chk(errFlag == e.err, "R8/R9 err", 32'(errFlag), 32'(e.err));
        chk(errCause == e.cause, "R8/R9 cause", 32'(errCause), 32'(e.cause));
        if (e.useRx) chk(rxData == e.rx, "R6 rxData", 32'(rxData), 32'(e.rx));
      end
    end
    irqSeen <= irq;
  end

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic setup(input logic [2:0] ph, input logic [DW-1:0] tx);
    cpuPhaseWe = 1; cpuPhaseVal = ph; cpuTxWe = 1; cpuTxVal = tx;
    tick();
    cpuPhaseWe = 0; cpuTxWe = 0;
  endtask

  task automatic arm();
    cpuStart = 1; tick(); cpuStart = 0;
  endtask

  task automatic waitReq(input logic lvl);
    int n = 0;
    while (busReq != lvl && n < 200) begin tick(); n++; end
  endtask

  task automatic clearAll();
    int n = 0;
    while (expQ.size() != 0 && n < 100) begin tick(); n++; end
    cpuClrWe = 1; cpuClrMask = 2'b11; tick(); cpuClrWe = 0; cpuClrMask = 0;
    chk(irq == 1'b0, "R10 cleared", 32'(irq), 32'd0);
  endtask

  // initiator side of one handshake
  task automatic initiator(input logic [DW-1:0] din, input logic par, input int holdHi);
    waitReq(1'b1);
    busDataIn = din; busParIn = par;
    busAck = 1;
    waitReq(1'b0);
    repeat (holdHi) tick();
    busAck = 0;
  endtask

  initial begin
    expItem_t e;
    repeat (3) tick();
    // R1 reset state
    chk({busReq, busDataOe, irq, startBit, doneFlag, errFlag} == 6'b0, "R1 reset outs",
        32'({busReq, busDataOe, irq, startBit, doneFlag, errFlag}), 32'd0);
    chk(busPhase == 3'b0 && errCause == 2'b0, "R1 reset phase/cause", 32'({busPhase, errCause}), 32'd0);
    rstN = 1; tick();

    // Outbound byte, phase {msg=1,cd=1,io=1}
    setup(3'b111, 8'hA5);
    e = '{done:1'b1, err:1'b0, cause:2'b00, useRx:1'b0, rx:'0};
    expQ.push_back(e);
    arm();
    chk(startBit == 1'b1, "R2 start set", 32'(startBit), 32'd1);
    chk(busReq == 1'b0, "R2 no req yet", 32'(busReq), 32'd0);
    tick();
    chk(startBit == 1'b0, "R2 start self-clear", 32'(startBit), 32'd0);
    chk(busDataOe == 1'b1 && busReq == 1'b0, "R4 data before req", 32'({busDataOe, busReq}), 32'h2);
    tick();
    chk(busReq == 1'b1, "R2 req rise", 32'(busReq), 32'd1);
    chk(busPhase == 3'b111, "R3 phase driven", 32'(busPhase), 32'h7);
    chk(busDataOut == 8'hA5, "R4 data", 32'(busDataOut), 32'hA5);
    chk(busParOut == 1'b1, "R4 odd parity", 32'(busParOut), 32'd1);
    // R3: phase write mid-handshake must not reach the bus
    cpuPhaseWe = 1; cpuPhaseVal = 3'b010; tick(); cpuPhaseWe = 0;
    chk(busPhase == 3'b111, "R3 snapshot", 32'(busPhase), 32'h7);
    // R11: start while busy
    arm();
    // R5: REQ held without ACK
    repeat (3) tick();
    chk(busReq == 1'b1, "R5 req held", 32'(busReq), 32'd1);
    busAck = 1;
    waitReq(1'b0);
    repeat (4) tick();
    chk(doneFlag == 1'b0 && busReq == 1'b0, "R5 no done while ack high", 32'({doneFlag, busReq}), 32'd0);
    chk(busDataOe == 1'b1, "R4 oe held to end", 32'(busDataOe), 32'd1);
    busAck = 0;
    repeat (4) tick();
    chk(doneFlag == 1'b1 && irq == 1'b1, "R7 done irq", 32'({doneFlag, irq}), 32'h3);
    repeat (6) tick();
    chk(busReq == 1'b0 && startBit == 1'b0, "R11 no second xfer", 32'({busReq, startBit}), 32'd0);
    chk(busPhase == 3'b0, "R3 idle phase zero", 32'(busPhase), 32'd0);
    // R10: mask 0 leaves done, then clear
    cpuClrWe = 1; cpuClrMask = 2'b10; tick(); cpuClrWe = 0; cpuClrMask = 0;
    chk(doneFlag == 1'b1, "R10 mask bit 0 kept", 32'(doneFlag), 32'd1);
    clearAll();

    // Inbound good parity: 8'h3C has 4 ones -> par 1
    setup(3'b010, 8'h00);
    e = '{done:1'b1, err:1'b0, cause:2'b00, useRx:1'b1, rx:8'h3C};
    expQ.push_back(e);
    arm();
    fork
      initiator(8'h3C, 1'b1, 2);
      begin
        waitReq(1'b1);
        chk(busDataOe == 1'b0, "R6 no drive inbound", 32'(busDataOe), 32'd0);
        chk(busPhase == 3'b010, "R3 inbound phase", 32'(busPhase), 32'h2);
      end
    join
    repeat (6) tick();
    clearAll();

    // Inbound bad parity: 8'h81 has 2 ones, par 0 -> even
    setup(3'b000, 8'h00);
    e = '{done:1'b1, err:1'b1, cause:2'b01, useRx:1'b1, rx:8'h81};
    expQ.push_back(e);
    arm();
    initiator(8'h81, 1'b0, 0);
    repeat (6) tick();
    chk(errCause == 2'b01, "R8 parity cause", 32'(errCause), 32'h1);
    cpuClrWe = 1; cpuClrMask = 2'b01; tick(); cpuClrWe = 0; cpuClrMask = 0;
    chk(errFlag == 1'b1 && irq == 1'b1, "R10 err kept by mask", 32'({errFlag, irq}), 32'h3);
    clearAll();

    // Timeout waiting for ACK high
    setup(3'b001, 8'h0F);
    e = '{done:1'b0, err:1'b1, cause:2'b10, useRx:1'b0, rx:'0};
    expQ.push_back(e);
    arm();
    waitReq(1'b1);
    waitReq(1'b0);
    tick();
    chk(busReq == 1'b0 && busDataOe == 1'b0, "R9 req dropped", 32'({busReq, busDataOe}), 32'd0);
    repeat (3) tick();
    clearAll();

    // Timeout waiting for ACK low (ACK stuck high)
    setup(3'b000, 8'h00);
    e = '{done:1'b0, err:1'b1, cause:2'b10, useRx:1'b0, rx:'0};
    expQ.push_back(e);
    arm();
    waitReq(1'b1);
    busDataIn = 8'h01; busParIn = 1'b0;
    busAck = 1;
    repeat (TMO + 10) tick();
    chk(errCause == 2'b10 && doneFlag == 1'b0, "R9 stuck ack", 32'({doneFlag, errCause}), 32'h2);
    busAck = 0;
    repeat (4) tick();
    clearAll();

    chk(expQ.size() == 0, "R7 scoreboard drained", 32'(expQ.size()), 32'd0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule